// File: doc/BRIEF.md
# Dual-Window Downstream Memory Decoder

This block decides, for every processor memory request, whether the request address belongs to the PCI Express port. Two address windows are programmable. One is a general window and the other is a prefetchable window. Each window has a lower bound and an upper bound, and both bounds are inclusive. A single enable bit in a command register opens or closes both windows together. A hit in the prefetchable window is reported on its own flag, so that the requester can apply a write-combining attribute to that range.

Software programs the block through a small register port. It has a write strobe, a 3-bit register index, and write data that is one bound field wide. Read data is combinational from the index. Every bound field stores address bits [31:20], so the windows have a granularity of 1 MB. The lower bound is filled out with zeros below bit 20 and the upper bound with ones. The decode result is registered and appears one clock after a valid request, together with a result strobe.

The enable bit is kept by a two-state gate machine. It starts in GATE_CLOSED after reset. A command write with bit 0 set moves it from GATE_CLOSED to GATE_OPEN. A command write with bit 0 clear moves it from GATE_OPEN back to GATE_CLOSED. Any other write leaves the state unchanged.

Top module: `dwin_decoder`

## Requirements
- R1: After reset, rsp_valid, rsp_route, rsp_mem_hit and rsp_pf_hit are 0, and every register index reads back 0.
- R2: Register indices are: 0 command (bit 0 is the enable bit, the other bits read 0), 1 general lower bound, 2 general upper bound, 3 prefetchable lower bound, 4 prefetchable upper bound. Each bound holds address bits [31:20] in data bits [11:0]. Indices 5 to 7 read 0, and writes to them change no register.
- R3: An address hits a window when {lower,20'h00000} <= address <= {upper,20'hFFFFF}. Both ends are inclusive.
- R4: A window whose upper bound field is below its lower bound field never hits.
- R5: While the enable bit is 0, no request produces a route or a hit flag, whatever the bounds are.
- R6: rsp_valid is high in the cycle after each cycle in which req_valid is high, and low otherwise. While rsp_valid is low, all three result flags are 0.
- R7: rsp_route is 1 exactly when the address falls in at least one enabled window.
- R8: rsp_pf_hit flags a prefetchable-window hit. Where the two windows overlap, rsp_pf_hit is 1, rsp_mem_hit is 0 and rsp_route is 1.
- R9: A register write is seen by requests that arrive in the following cycle or later. A request in the same cycle as the write is decoded with the old values.
- R10: The gate machine moves GATE_CLOSED to GATE_OPEN on a command write with bit 0 set, and GATE_OPEN to GATE_CLOSED on a command write with bit 0 clear. Bits 11:1 of a command write and writes to other indices do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index for read and write |
| cfg_wdata | input | 12 | Register write data |
| cfg_rdata | output | 12 | Read data of the indexed register |
| req_valid | input | 1 | Request address valid |
| req_addr | input | 32 | Request address |
| rsp_valid | output | 1 | Decode result valid, one cycle after the request |
| rsp_route | output | 1 | Route the request to the PCI Express port |
| rsp_mem_hit | output | 1 | Hit in the general window only |
| rsp_pf_hit | output | 1 | Hit in the prefetchable window |

## Verification
The assertions check on every cycle that the following rules hold:
- The result strobe follows the request strobe by one clock.
- The flags stay quiet while no result is valid.
- The route equals the OR of the two hit flags, and the two flags are never high together.
- A closed gate yields no route.
- A request whose address lies below the prefetchable lower bound yields no prefetchable hit.

Some behaviour only the bench scenarios can show:
- The exact inclusive edges at both ends of each window.
- An inverted window that never hits.
- Overlap priority.
- The one-cycle visibility of a register write.
- The gate transitions.
- Writes to unused indices that leave everything unchanged.

// File: rtl/pcie_win_pkg.sv
package pcie_win_pkg;

    localparam int NUM_WIN = 2;
    localparam int WIN_MEM = 0;
    localparam int WIN_PF  = 1;
    localparam int CFG_AW  = 3;

    localparam logic [CFG_AW-1:0] RIDX_CMD = 3'd0;

    typedef enum logic {
        GATE_CLOSED = 1'b0,
        GATE_OPEN   = 1'b1
    } gate_state_e;

    // register index of a window's lower bound; the upper bound follows it
    function automatic logic [CFG_AW-1:0] lo_index(input int w);
        return CFG_AW'(1 + 2 * w);
    endfunction

    function automatic logic [CFG_AW-1:0] hi_index(input int w);
        return CFG_AW'(2 + 2 * w);
    endfunction

endpackage

// File: rtl/win_gate.sv
module win_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_wr,
    input  logic cmd_en_bit,
    output logic mem_en
);
    import pcie_win_pkg::*;

    gate_state_e state_q;
    gate_state_e state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= GATE_CLOSED;
        else        state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            GATE_CLOSED: if (cmd_wr && cmd_en_bit)  state_nx = GATE_OPEN;
            GATE_OPEN:   if (cmd_wr && !cmd_en_bit) state_nx = GATE_CLOSED;
        endcase
    end

    always_comb begin
        mem_en = (state_q == GATE_OPEN);
    end

endmodule

// File: rtl/win_regs.sv
module win_regs #(
    parameter int FW = 12
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        cfg_wr,
    input  logic [pcie_win_pkg::CFG_AW-1:0]             cfg_addr,
    input  logic [FW-1:0]                               cfg_wdata,
    output logic [FW-1:0]                               cfg_rdata,
    output logic                                        mem_en,
    output logic [pcie_win_pkg::NUM_WIN-1:0][FW-1:0]    win_lo,
    output logic [pcie_win_pkg::NUM_WIN-1:0][FW-1:0]    win_hi
);
    import pcie_win_pkg::*;

    logic cmd_wr;
    assign cmd_wr = cfg_wr && (cfg_addr == RIDX_CMD);

    win_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_wr     (cmd_wr),
        .cmd_en_bit (cfg_wdata[0]),
        .mem_en     (mem_en)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_bound
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                win_lo[w] <= '0;
                win_hi[w] <= '0;
            end else if (cfg_wr) begin
                if (cfg_addr == lo_index(w)) win_lo[w] <= cfg_wdata;
                if (cfg_addr == hi_index(w)) win_hi[w] <= cfg_wdata;
            end
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (cfg_addr == RIDX_CMD) cfg_rdata = {{(FW-1){1'b0}}, mem_en};
        for (int w = 0; w < NUM_WIN; w++) begin
            if (cfg_addr == lo_index(w)) cfg_rdata = win_lo[w];
            if (cfg_addr == hi_index(w)) cfg_rdata = win_hi[w];
        end
    end

endmodule

// File: rtl/win_compare.sv
module win_compare #(
    parameter int ADDR_W = 32,
    parameter int FW     = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [FW-1:0]     lo,
    input  logic [FW-1:0]     hi,
    output logic              hit
);
    localparam int LOWB = ADDR_W - FW;

    logic [ADDR_W-1:0] lo_full;
    logic [ADDR_W-1:0] hi_full;

    assign lo_full = {lo, {LOWB{1'b0}}};
    assign hi_full = {hi, {LOWB{1'b1}}};
    assign hit     = (addr >= lo_full) && (addr <= hi_full);

endmodule

// File: rtl/dwin_decoder.sv
module dwin_decoder #(
    parameter int ADDR_W    = 32,
    parameter int GRAN_LOG2 = 20
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 cfg_wr,
    input  logic [pcie_win_pkg::CFG_AW-1:0]      cfg_addr,
    input  logic [ADDR_W-GRAN_LOG2-1:0]          cfg_wdata,
    output logic [ADDR_W-GRAN_LOG2-1:0]          cfg_rdata,
    input  logic                                 req_valid,
    input  logic [ADDR_W-1:0]                    req_addr,
    output logic                                 rsp_valid,
    output logic                                 rsp_route,
    output logic                                 rsp_mem_hit,
    output logic                                 rsp_pf_hit
);
    import pcie_win_pkg::*;

    localparam int FW = ADDR_W - GRAN_LOG2;

    logic                        mem_en;
    logic [NUM_WIN-1:0][FW-1:0]  win_lo;
    logic [NUM_WIN-1:0][FW-1:0]  win_hi;
    logic [NUM_WIN-1:0]          raw_hit;
    logic [NUM_WIN-1:0]          gated_hit;

    win_regs #(.FW(FW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .mem_en    (mem_en),
        .win_lo    (win_lo),
        .win_hi    (win_hi)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        win_compare #(.ADDR_W(ADDR_W), .FW(FW)) u_cmp (
            .addr (req_addr),
            .lo   (win_lo[w]),
            .hi   (win_hi[w]),
            .hit  (raw_hit[w])
        );
        assign gated_hit[w] = raw_hit[w] & mem_en;
    end

    // result stage: prefetchable flag wins on overlap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_route   <= 1'b0;
            rsp_mem_hit <= 1'b0;
            rsp_pf_hit  <= 1'b0;
        end else begin
            rsp_valid   <= req_valid;
            rsp_route   <= req_valid & (|gated_hit);
            rsp_pf_hit  <= req_valid & gated_hit[WIN_PF];
            rsp_mem_hit <= req_valid & gated_hit[WIN_MEM] & ~gated_hit[WIN_PF];
        end
    end

endmodule

// File: rtl/dwin_decoder_chk.sv
module dwin_decoder_chk #(
    parameter int FW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [FW-1:0] req_page,
    input logic          mem_en,
    input logic [FW-1:0] pf_lo,
    input logic          rsp_valid,
    input logic          rsp_route,
    input logic          rsp_mem_hit,
    input logic          rsp_pf_hit
);

    p_rsp_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_rsp_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    p_flags_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(rsp_route || rsp_mem_hit || rsp_pf_hit));

    p_route_is_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_route == (rsp_mem_hit || rsp_pf_hit)));

    p_hit_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_mem_hit, rsp_pf_hit}));

    p_gate_closed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !mem_en) |=> !rsp_route);

    p_below_pf_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_page < pf_lo)) |=> !rsp_pf_hit);

endmodule

bind dwin_decoder dwin_decoder_chk #(.FW(FW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_page    (req_addr[ADDR_W-1 -: FW]),
    .mem_en      (mem_en),
    .pf_lo       (win_lo[pcie_win_pkg::WIN_PF]),
    .rsp_valid   (rsp_valid),
    .rsp_route   (rsp_route),
    .rsp_mem_hit (rsp_mem_hit),
    .rsp_pf_hit  (rsp_pf_hit)
);

// File: tb/test_dwin_decoder.sv
`timescale 1ns/1ps
module test_dwin_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [11:0] cfg_wdata = '0;
    logic [11:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        rsp_valid, rsp_route, rsp_mem_hit, rsp_pf_hit;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench-side view of programmed state
    logic        m_en = 1'b0;
    logic [11:0] m_lo [2] = '{12'h0, 12'h0};
    logic [11:0] m_hi [2] = '{12'h0, 12'h0};

    logic [2:0] exp_q [$];
    string      tag_q [$];

    always #5 clk = ~clk;

    dwin_decoder i_dwin_decoder (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_route(rsp_route),
        .rsp_mem_hit(rsp_mem_hit), .rsp_pf_hit(rsp_pf_hit)
    );

    function automatic logic [2:0] model(input logic [31:0] a);
        logic h0, h1;
        h0 = m_en && (a >= {m_lo[0], 20'h00000}) && (a <= {m_hi[0], 20'hFFFFF});
        h1 = m_en && (a >= {m_lo[1], 20'h00000}) && (a <= {m_hi[1], 20'hFFFFF});
        return {h0 | h1, h0 & ~h1, h1}; // {route, mem, pf}
    endfunction

    task automatic shadow_write(input logic [2:0] a, input logic [11:0] d);
        case (a)
            3'd0: m_en = d[0];
            3'd1: m_lo[0] = d;
            3'd2: m_hi[0] = d;
            3'd3: m_lo[1] = d;
            3'd4: m_hi[1] = d;
            default: ;
        endcase
    endtask

    task automatic cfg_write(input logic [2:0] a, input logic [11:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); #1;
        shadow_write(a, d);
        cfg_wr = 1'b0;
    endtask

    task automatic send_req(input logic [31:0] a, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(posedge clk); #1;
        exp_q.push_back(model(a));
        tag_q.push_back(tag);
        req_valid = 1'b0;
    endtask

    // write and request in the same cycle: request must see old values
    task automatic write_and_req(input logic [2:0] ra, input logic [11:0] d,
                                 input logic [31:0] a, input string tag);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = ra; cfg_wdata = d;
        req_valid = 1'b1; req_addr = a;
        @(posedge clk); #1;
        exp_q.push_back(model(a));
        tag_q.push_back(tag);
        shadow_write(ra, d);
        cfg_wr = 1'b0; req_valid = 1'b0;
    endtask

    task automatic rd_check(input logic [2:0] a, input logic [11:0] exp, input string tag);
        @(negedge clk);
        cfg_addr = a;
        #1;
        checks++;
        if (cfg_rdata !== exp) begin
            fails++;
            $display("FAIL %s: read index %0d got %h expected %h", tag, a, cfg_rdata, exp);
        end
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (exp_q.size() > 0) begin
                    logic [2:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    checks++;
                    if (!rsp_valid || {rsp_route, rsp_mem_hit, rsp_pf_hit} !== e) begin
                        fails++;
                        $display("FAIL %s: valid=%b route/mem/pf=%b%b%b expected valid=1 %b",
                                 t, rsp_valid, rsp_route, rsp_mem_hit, rsp_pf_hit, e);
                    end
                end else if (rsp_valid || rsp_route || rsp_mem_hit || rsp_pf_hit) begin
                    checks++;
                    fails++;
                    $display("FAIL R6: idle outputs valid=%b flags=%b%b%b expected 0 000",
                             rsp_valid, rsp_route, rsp_mem_hit, rsp_pf_hit);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        @(negedge clk);
        checks++;
        if (rsp_valid || rsp_route || rsp_mem_hit || rsp_pf_hit) begin
            fails++;
            $display("FAIL R1: outputs %b%b%b%b expected 0000",
                     rsp_valid, rsp_route, rsp_mem_hit, rsp_pf_hit);
        end
        for (int i = 0; i < 8; i++) rd_check(3'(i), 12'h000, "R1");

        // R5: closed gate with zero bounds
        send_req(32'h0000_0000, "R5 closed at reset");
        send_req(32'h000F_FFFF, "R5 closed at reset");

        // R2: program bounds and read back
        cfg_write(3'd1, 12'h800);
        cfg_write(3'd2, 12'h8FF);
        cfg_write(3'd3, 12'hA00);
        cfg_write(3'd4, 12'hA3F);
        rd_check(3'd1, 12'h800, "R2");
        rd_check(3'd2, 12'h8FF, "R2");
        rd_check(3'd3, 12'hA00, "R2");
        rd_check(3'd4, 12'hA3F, "R2");
        rd_check(3'd0, 12'h000, "R10 bound writes keep gate closed");
        send_req(32'h8000_0000, "R5 programmed but closed");
        send_req(32'hA000_0000, "R5 programmed but closed");

        // R10: upper command bits do not open
        cfg_write(3'd0, 12'hFFE);
        rd_check(3'd0, 12'h000, "R10 bit0 clear stays closed");
        cfg_write(3'd0, 12'h001);
        rd_check(3'd0, 12'h001, "R10 open");

        // R3/R7/R8: window edges, back-to-back
        send_req(32'h7FFF_FFFF, "R3 below general");
        send_req(32'h8000_0000, "R3 general low edge");
        send_req(32'h8FFF_FFFF, "R3 general high edge");
        send_req(32'h9000_0000, "R7 gap");
        send_req(32'h9FFF_FFFF, "R3 below pf");
        send_req(32'hA000_0000, "R8 pf low edge");
        send_req(32'hA3FF_FFFF, "R8 pf high edge");
        send_req(32'hA400_0000, "R7 above pf");
        send_req(32'hFFFF_FFFF, "R7 top of space");

        // R4: inverted general window
        cfg_write(3'd1, 12'h901);
        cfg_write(3'd2, 12'h900);
        send_req(32'h9000_0000, "R4 inverted");
        send_req(32'h9010_0000, "R4 inverted");
        send_req(32'h8800_0000, "R4 inverted");

        // R8: overlap priority
        cfg_write(3'd1, 12'hA00);
        cfg_write(3'd2, 12'hAFF);
        send_req(32'hA100_0000, "R8 overlap");
        send_req(32'hA800_0000, "R8 general only part");

        // R9: same-cycle write sees old values, next cycle new
        write_and_req(3'd4, 12'hA00, 32'hA200_0000, "R9 same cycle old");
        send_req(32'hA200_0000, "R9 next cycle new");
        send_req(32'hA00F_FFFF, "R9 shrunk pf edge");
        send_req(32'hA010_0000, "R9 shrunk pf past edge");

        // R2: unused indices
        cfg_write(3'd5, 12'hFFF);
        cfg_write(3'd6, 12'h123);
        cfg_write(3'd7, 12'h000);
        rd_check(3'd5, 12'h000, "R2 unused");
        rd_check(3'd7, 12'h000, "R2 unused");
        rd_check(3'd0, 12'h001, "R2 unused write kept command");
        rd_check(3'd1, 12'hA00, "R2 unused write kept bound");
        rd_check(3'd4, 12'hA00, "R2 unused write kept bound");
        send_req(32'hA800_0000, "R2 decode unchanged");

        // R10/R5: close gate
        cfg_write(3'd0, 12'h000);
        rd_check(3'd0, 12'h000, "R10 close");
        send_req(32'hA000_0000, "R5 closed again");
        send_req(32'hA800_0000, "R5 closed again");

        repeat (4) @(posedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule